// File: doc/BRIEF.md
# Potentiometer Step Sequencer

This block sits in the system-clock domain and drives the three control lines of a 128-position up/down digital potentiometer: an active-low select, a direction level and an active-low step strobe. The device moves its wiper one position on each falling edge of the strobe while selected. Whether the device writes the position to its non-volatile memory depends on the level of the strobe at the moment select is released. The sequencer keeps its own copy of the wiper position. It takes one command at a time, made of a target position, a store flag and a homing flag. It works out how far the wiper must move and in which direction, then plays out the strobe train. Every setup, pulse-width and hold interval is a parameter counted in clock cycles.

A command whose target equals the tracked position and that does not ask for a store finishes at once, without touching the lines. A homing command ignores the target and sends one pulse fewer than the number of positions, in the down direction. The device saturates at its ends, so this reaches position 0 from any starting point and brings the tracked copy back in line with the device.

States: `S_IDLE` (ready, lines parked high), `S_SELECT` (select low, setup wait), `S_STEP_LOW` and `S_STEP_HIGH` (the two phases of one strobe pulse), `S_PRE_STORE` (strobe high, gap before a storing release), `S_STORE_HOLD` (select high during the store time), `S_SKIP_HOLD` (select released with the strobe still low) and `S_REARM` (strobe back high, direction hold). Transitions: IDLE→SELECT on an accepted command that needs the lines; IDLE→IDLE with `done` for a zero-move command without a store; SELECT→STEP_LOW when pulses remain, or SELECT→PRE_STORE when none remain; STEP_LOW→STEP_HIGH, or STEP_LOW→SKIP_HOLD after the last pulse of a command without a store; STEP_HIGH→STEP_LOW while pulses remain, else STEP_HIGH→PRE_STORE; PRE_STORE→STORE_HOLD; STORE_HOLD→IDLE; SKIP_HOLD→REARM; REARM→IDLE. Each timed state lasts exactly its parameter count, and every return to IDLE raises `done`.

Top module: `pot_step_seq`

## Requirements
- R1: After reset `pot_cs_n` and `pot_inc_n` are 1, `cmd_ready` is 1, `done` is 0 and `pos` equals `POS_RESET`.
- R2: A non-homing command moves the device by exactly |target − pos| strobe pulses and leaves `pos` equal to the target.
- R3: `pot_up` = 1 marks upward steps (target above `pos`) and `pot_up` = 0 marks downward steps; it stays constant for a whole command.
- R4: Every falling edge of `pot_inc_n` happens while `pot_cs_n` is 0. `pot_cs_n` has been low for at least `CS_SETUP_CYC` cycles and `pot_up` steady for at least `DIR_SETUP_CYC` cycles before the edge.
- R5: Each low phase of `pot_inc_n` lasts at least `STEP_LOW_CYC` cycles and each high phase between two pulses at least `STEP_HIGH_CYC` cycles.
- R6: `pot_up` changes only while `pot_inc_n` is 1, and no earlier than `DIR_HOLD_CYC` cycles after its last rising edge.
- R7: With the store flag set, `pot_cs_n` rises while `pot_inc_n` is 1, at least `RELEASE_GAP_CYC` cycles after the last rising edge of `pot_inc_n`. It then stays high for at least `STORE_HOLD_CYC` cycles before falling again.
- R8: With the store flag clear, `pot_cs_n` rises while `pot_inc_n` is 0, at least `RELEASE_GAP_CYC` cycles after the last falling edge. It stays high for at least `SKIP_HOLD_CYC` cycles before `pot_inc_n` returns high.
- R9: A command with target equal to `pos`, store clear and homing clear raises `done` in the cycle after acceptance, and `pot_cs_n` never goes low.
- R10: A homing command sends 2^POS_W − 1 downward pulses and leaves `pos` at 0, whatever the device position was.
- R11: `cmd_ready` is 1 only in the idle state. A `cmd_valid` seen while `cmd_ready` is 0 has no effect on the lines, `pos` or `done`.
- R12: `done` is a single-cycle pulse, raised only while `cmd_ready` is 1, once per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command taken on this cycle if valid |
| cmd_target | input | POS_W | Target wiper position |
| cmd_store | input | 1 | 1: release with a store; 0: release without a store |
| cmd_home | input | 1 | 1: homing command, target ignored |
| done | output | 1 | One-cycle completion pulse |
| pos | output | POS_W | Tracked wiper position |
| pot_cs_n | output | 1 | Active-low device select |
| pot_up | output | 1 | Direction level, 1 = up |
| pot_inc_n | output | 1 | Active-low step strobe, falling edge steps |

## Verification
A corrupted remaining-pulse count or tracked position shows up on the device model as a wrong pulse total or final wiper value, and it is visible on `pos` as soon as the command's `done` appears. A state-machine fault that reorders the release shows up at the first rising edge of `pot_cs_n`: the model records a store where none was asked for, or the reverse. A shortened wait shows up at the very next line edge as a setup, width or hold interval measured below its parameter. A fault in acceptance shows up within a cycle as an early `done`, a `done` without a command, or a line that moves during a zero-move command.

// File: rtl/pot_seq_pkg.sv
`timescale 1ns/1ps
package pot_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SELECT,
        S_STEP_LOW,
        S_STEP_HIGH,
        S_PRE_STORE,
        S_STORE_HOLD,
        S_SKIP_HOLD,
        S_REARM
    } seq_state_e;

    function automatic int cmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pot_seq_timer.sv
`timescale 1ns/1ps
module pot_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // R5: a freshly loaded non-zero count never reads as expired on the next cycle
    p_timer_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !zero);

endmodule

// File: rtl/pot_seq_tracker.sv
`timescale 1ns/1ps
module pot_seq_tracker #(
    parameter int POS_W     = 7,
    parameter int POS_RESET = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             up,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] TOP_TAP = {POS_W{1'b1}};

    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= POS_W'(POS_RESET);
        end else if (step) begin
            if (up && pos_q != TOP_TAP) begin
                pos_q <= pos_q + 1'b1;
            end else if (!up && pos_q != '0) begin
                pos_q <= pos_q - 1'b1;
            end
        end
    end

    assign pos = pos_q;

    // R10: the copy saturates like the device, so homing settles at 0
    p_floor_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !up && pos_q == '0) |=> (pos_q == '0));
    p_top_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && up && pos_q == TOP_TAP) |=> (pos_q == TOP_TAP));

endmodule

// File: rtl/pot_step_seq.sv
`timescale 1ns/1ps
module pot_step_seq
    import pot_seq_pkg::*;
#(
    parameter int POS_W          = 7,
    parameter int POS_RESET      = 0,
    parameter int CS_SETUP_CYC   = 20,
    parameter int DIR_SETUP_CYC  = 200,
    parameter int DIR_HOLD_CYC   = 20,
    parameter int STEP_LOW_CYC   = 200,
    parameter int STEP_HIGH_CYC  = 200,
    parameter int RELEASE_GAP_CYC = 200,
    parameter int STORE_HOLD_CYC = 4000000,
    parameter int SKIP_HOLD_CYC  = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [POS_W-1:0] cmd_target,
    input  logic             cmd_store,
    input  logic             cmd_home,
    output logic             done,
    output logic [POS_W-1:0] pos,
    output logic             pot_cs_n,
    output logic             pot_up,
    output logic             pot_inc_n
);
    localparam int L_SEL      = cmax(CS_SETUP_CYC, DIR_SETUP_CYC);
    localparam int L_LOW_LAST = cmax(STEP_LOW_CYC, RELEASE_GAP_CYC);
    localparam int L_MAX      = cmax(cmax(cmax(L_SEL, L_LOW_LAST), cmax(STEP_HIGH_CYC, RELEASE_GAP_CYC)),
                                     cmax(cmax(STORE_HOLD_CYC, SKIP_HOLD_CYC), DIR_HOLD_CYC));
    localparam int CNT_W      = $clog2(L_MAX + 1);
    localparam logic [POS_W-1:0] TOP_TAP = {POS_W{1'b1}};

    seq_state_e       state_q, state_d;
    logic [POS_W-1:0] rem_q;
    logic             up_q, store_q, done_q, done_d;
    logic             accept, step_ev, t_load, t_zero;
    logic [CNT_W-1:0] t_val;
    logic [POS_W-1:0] req_rem;
    logic             req_up;

    assign accept = (state_q == S_IDLE) && cmd_valid;

    // distance and direction of the requested move
    always_comb begin
        if (cmd_home) begin
            req_rem = TOP_TAP;
            req_up  = 1'b0;
        end else if (cmd_target >= pos) begin
            req_rem = cmd_target - pos;
            req_up  = 1'b1;
        end else begin
            req_rem = pos - cmd_target;
            req_up  = 1'b0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        done_d  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    if (req_rem == '0 && !cmd_store) done_d  = 1'b1;
                    else                             state_d = S_SELECT;
                end
            end
            S_SELECT: begin
                if (t_zero) state_d = (rem_q == '0) ? S_PRE_STORE : S_STEP_LOW;
            end
            S_STEP_LOW: begin
                if (t_zero) state_d = (rem_q == '0 && !store_q) ? S_SKIP_HOLD : S_STEP_HIGH;
            end
            S_STEP_HIGH: begin
                if (t_zero) state_d = (rem_q != '0) ? S_STEP_LOW : S_PRE_STORE;
            end
            S_PRE_STORE: begin
                if (t_zero) state_d = S_STORE_HOLD;
            end
            S_STORE_HOLD: begin
                if (t_zero) begin
                    state_d = S_IDLE;
                    done_d  = 1'b1;
                end
            end
            S_SKIP_HOLD: begin
                if (t_zero) state_d = S_REARM;
            end
            S_REARM: begin
                if (t_zero) begin
                    state_d = S_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // dwell of the state being entered
    always_comb begin
        t_val = '0;
        unique case (state_d)
            S_IDLE:       t_val = '0;
            S_SELECT:     t_val = CNT_W'(L_SEL - 1);
            S_STEP_LOW:   t_val = (rem_q == POS_W'(1) && !store_q) ? CNT_W'(L_LOW_LAST - 1)
                                                                   : CNT_W'(STEP_LOW_CYC - 1);
            S_STEP_HIGH:  t_val = CNT_W'(STEP_HIGH_CYC - 1);
            S_PRE_STORE:  t_val = CNT_W'(RELEASE_GAP_CYC - 1);
            S_STORE_HOLD: t_val = CNT_W'(STORE_HOLD_CYC - 1);
            S_SKIP_HOLD:  t_val = CNT_W'(SKIP_HOLD_CYC - 1);
            S_REARM:      t_val = CNT_W'(DIR_HOLD_CYC - 1);
            default:      t_val = '0;
        endcase
    end

    assign t_load  = (state_d != state_q);
    assign step_ev = (state_d == S_STEP_LOW) && (state_q != S_STEP_LOW);

    // state register and command context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            done_q  <= 1'b0;
            rem_q   <= '0;
            up_q    <= 1'b1;
            store_q <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
            if (state_q == S_IDLE && state_d == S_SELECT) begin
                rem_q   <= req_rem;
                up_q    <= req_up;
                store_q <= cmd_store;
            end else if (step_ev) begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cmd_ready = (state_q == S_IDLE);
        done      = done_q;
        pot_up    = up_q;
        pot_cs_n  = (state_q == S_IDLE) || (state_q == S_STORE_HOLD) ||
                    (state_q == S_SKIP_HOLD) || (state_q == S_REARM);
        pot_inc_n = !((state_q == S_STEP_LOW) || (state_q == S_SKIP_HOLD));
    end

    pot_seq_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    pot_seq_tracker #(.POS_W(POS_W), .POS_RESET(POS_RESET)) i_tracker (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step_ev),
        .up    (up_q),
        .pos   (pos)
    );

    p_idle_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (pot_cs_n && pot_inc_n));

    p_pos_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos != $past(pos)) |-> ($past(pot_inc_n) && !pot_inc_n));

    p_step_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pot_inc_n) |-> (!pot_cs_n && !$past(pot_cs_n)));

    p_dir_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pot_inc_n |-> $stable(pot_up));

    // R7 and R8: the strobe level at release matches the store flag
    p_release_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pot_cs_n) |-> (pot_inc_n == store_q));

    p_zero_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid && !cmd_home && !cmd_store && cmd_target == pos)
        |=> (done && pot_cs_n));

    p_busy_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && cmd_valid) |=> $stable(pot_up));

    p_done_in_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

endmodule

// File: tb/test_pot_step_seq.sv
`timescale 1ns/1ps
module test_pot_step_seq;
    localparam int POS_W  = 7;
    localparam int TOPV   = (1 << POS_W) - 1;
    localparam int CS_SU  = 2;
    localparam int DIR_SU = 4;
    localparam int DIR_HD = 3;
    localparam int LOW_W  = 3;
    localparam int HIGH_W = 5;
    localparam int GAP    = 4;
    localparam int ST_HD  = 20;
    localparam int SK_HD  = 6;
    localparam int WDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [POS_W-1:0] cmd_target = '0;
    logic cmd_store = 1'b0;
    logic cmd_home = 1'b0;
    logic done;
    logic [POS_W-1:0] pos;
    logic pot_cs_n, pot_up, pot_inc_n;

    always #2.5 clk = ~clk;

    pot_step_seq #(
        .POS_W(POS_W), .POS_RESET(0),
        .CS_SETUP_CYC(CS_SU), .DIR_SETUP_CYC(DIR_SU), .DIR_HOLD_CYC(DIR_HD),
        .STEP_LOW_CYC(LOW_W), .STEP_HIGH_CYC(HIGH_W), .RELEASE_GAP_CYC(GAP),
        .STORE_HOLD_CYC(ST_HD), .SKIP_HOLD_CYC(SK_HD)
    ) i_pot_step_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_target(cmd_target), .cmd_store(cmd_store), .cmd_home(cmd_home),
        .done(done), .pos(pos), .pot_cs_n(pot_cs_n), .pot_up(pot_up),
        .pot_inc_n(pot_inc_n)
    );

    int total = 0;
    int bad = 0;

    // device model and line monitor
    int dev_pos = 0, stored = -1;
    int n_up = 0, n_dn = 0, n_store = 0, n_skip = 0, n_csfall = 0, n_done = 0;
    int v4 = 0, v5 = 0, v6 = 0, v7 = 0, v8 = 0;
    int cyc = 0;
    int t_cs_fall = -100000, t_cs_rise = -100000, t_inc_fall = -100000;
    int t_inc_rise = -100000, t_dir = -100000;
    bit p_cs = 1'b1, p_inc = 1'b1, p_up = 1'b1, last_store = 1'b1, first_pulse = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (done) n_done++;
            if (p_cs && !pot_cs_n) begin
                n_csfall++;
                if (cyc - t_cs_rise < (last_store ? ST_HD : SK_HD)) begin
                    if (last_store) v7++; else v8++;
                end
                t_cs_fall = cyc;
                first_pulse = 1'b1;
            end
            if (pot_up != p_up) begin
                if (!pot_inc_n || cyc - t_inc_rise < DIR_HD) v6++;
                t_dir = cyc;
            end
            if (p_inc && !pot_inc_n) begin
                if (pot_cs_n) v4++;
                if (cyc - t_cs_fall < CS_SU || cyc - t_dir < DIR_SU) v4++;
                if (!first_pulse && cyc - t_inc_rise < HIGH_W) v5++;
                first_pulse = 1'b0;
                if (!pot_cs_n) begin
                    if (pot_up) begin n_up++; if (dev_pos < TOPV) dev_pos++; end
                    else begin n_dn++; if (dev_pos > 0) dev_pos--; end
                end
                t_inc_fall = cyc;
            end
            if (!p_inc && pot_inc_n) begin
                if (cyc - t_inc_fall < LOW_W) v5++;
                if (pot_cs_n && !last_store && cyc - t_cs_rise < SK_HD) v8++;
                t_inc_rise = cyc;
            end
            if (!p_cs && pot_cs_n) begin
                if (pot_inc_n) begin
                    n_store++; stored = dev_pos;
                    if (cyc - t_inc_rise < GAP) v7++;
                end else begin
                    n_skip++;
                    if (cyc - t_inc_fall < GAP) v8++;
                end
                last_store = pot_inc_n;
                t_cs_rise = cyc;
            end
            p_cs = pot_cs_n; p_inc = pot_inc_n; p_up = pot_up;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (WDOG) @(negedge clk);
        check(1'b0, "watchdog", cyc, WDOG);
        summary();
    end

    task automatic run_cmd(input int tgt, input bit st, input bit hm, input string req);
        int lat;
        @(negedge clk);
        cmd_target = POS_W'(tgt); cmd_store = st; cmd_home = hm; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_home = 1'b0;
        lat = 1;
        while (!done && lat < 20000) begin @(negedge clk); lat++; end
        check(done == 1'b1, req, int'(done), 1);
        @(negedge clk);
        check(done == 1'b0, "R12 done single cycle", int'(done), 0);
    endtask

    task automatic timing_clean(input string tag);
        check(v4 == 0, {"R4 setup ", tag}, v4, 0);
        check(v5 == 0, {"R5 widths ", tag}, v5, 0);
        check(v6 == 0, {"R6 dir hold ", tag}, v6, 0);
        check(v7 == 0, {"R7 store timing ", tag}, v7, 0);
        check(v8 == 0, {"R8 skip timing ", tag}, v8, 0);
    endtask

    task automatic t_reset();
        #1;
        check(pot_cs_n == 1'b1, "R1 cs_n", int'(pot_cs_n), 1);
        check(pot_inc_n == 1'b1, "R1 inc_n", int'(pot_inc_n), 1);
        check(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(pos == 0, "R1 pos", int'(pos), 0);
    endtask

    task automatic t_move_up();
        int u0 = n_up, s0 = n_skip, st0 = n_store;
        run_cmd(37, 1'b0, 1'b0, "R2 up done");
        check(n_up - u0 == 37, "R3 R2 up pulses", n_up - u0, 37);
        check(dev_pos == 37, "R2 device pos", dev_pos, 37);
        check(pos == 37, "R2 tracked pos", int'(pos), 37);
        check(n_skip - s0 == 1 && n_store == st0, "R8 release without store", n_skip - s0, 1);
        timing_clean("up");
    endtask

    task automatic t_move_down_store();
        int d0 = n_dn, u0 = n_up;
        run_cmd(10, 1'b1, 1'b0, "R2 down done");
        check(n_dn - d0 == 27 && n_up == u0, "R3 down pulses", n_dn - d0, 27);
        check(pos == 10, "R2 tracked pos", int'(pos), 10);
        check(stored == 10, "R7 stored value", stored, 10);
        timing_clean("down");
    endtask

    task automatic t_equal_skip();
        int c0 = n_csfall, d0 = n_done;
        @(negedge clk);
        cmd_target = 7'd10; cmd_store = 1'b0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(done == 1'b1, "R9 immediate done", int'(done), 1);
        repeat (10) @(negedge clk);
        check(n_csfall == c0, "R9 select untouched", n_csfall - c0, 0);
        check(n_done - d0 == 1, "R12 one done", n_done - d0, 1);
    endtask

    task automatic t_equal_store();
        int c0 = n_csfall, s0 = n_store, u0 = n_up, d0 = n_dn;
        stored = -1;
        run_cmd(10, 1'b1, 1'b0, "R7 zero-move store done");
        check(n_csfall - c0 == 1 && n_store - s0 == 1, "R7 store cycle", n_store - s0, 1);
        check(n_up == u0 && n_dn == d0, "R2 no pulses", n_up + n_dn - u0 - d0, 0);
        check(stored == 10, "R7 stored value", stored, 10);
        timing_clean("eqstore");
    endtask

    task automatic t_busy();
        int c0, lat;
        @(negedge clk);
        cmd_target = 7'd50; cmd_store = 1'b0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (20) @(negedge clk);
        check(cmd_ready == 1'b0, "R11 busy not ready", int'(cmd_ready), 0);
        cmd_target = 7'd3; cmd_store = 1'b1; cmd_valid = 1'b1;
        repeat (2) @(negedge clk);
        cmd_valid = 1'b0;
        lat = 0;
        while (!done && lat < 20000) begin @(negedge clk); lat++; end
        c0 = n_csfall;
        repeat (40) @(negedge clk);
        check(n_csfall == c0, "R11 busy command dropped", n_csfall - c0, 0);
        check(pos == 50 && dev_pos == 50, "R11 pos kept", int'(pos), 50);
        timing_clean("busy");
    endtask

    task automatic t_full_up();
        int u0 = n_up;
        run_cmd(TOPV, 1'b0, 1'b0, "R2 full-scale done");
        check(n_up - u0 == TOPV - 50, "R2 full-scale pulses", n_up - u0, TOPV - 50);
        check(pos == TOPV, "R2 top pos", int'(pos), TOPV);
    endtask

    task automatic t_home();
        int d0 = n_dn;
        @(negedge clk);
        dev_pos = 90;   // device drifted away from the tracked copy
        run_cmd(99, 1'b1, 1'b1, "R10 home done");
        check(n_dn - d0 == TOPV, "R10 home pulses", n_dn - d0, TOPV);
        check(dev_pos == 0 && pos == 0, "R10 resync", dev_pos, 0);
        check(stored == 0, "R7 home stored", stored, 0);
        run_cmd(5, 1'b0, 1'b0, "R2 after home");
        check(dev_pos == 5 && pos == 5, "R2 after home pos", dev_pos, 5);
        timing_clean("home");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_move_up();
        t_move_down_store();
        t_equal_skip();
        t_equal_store();
        t_busy();
        t_full_up();
        t_home();
        summary();
    end
endmodule